// File: doc/BRIEF.md
# Low/full-speed bus state transmitter

This block sits between the serial packet path and the two data-line drivers of a low-speed or full-speed port. The stream arriving at its input has already been NRZI-encoded and bit-stuffed. The block turns that stream into per-line drive values and an output enable, one line state per bit time. A bit-time strobe from the clock-recovery side marks where each bit time begins.

A packet starts on a strobe at which the requester holds `pkt_valid` high while the block is idle. The block then leaves the idle lines by driving a K. That K is the first SYNC symbol, and the block produces it by itself. On every later strobe it drives the next stream bit as J or K. When `pkt_valid` is low at a strobe, the block closes the packet: single-ended zero for two bit times, J for one bit time, then both lines are released. A keep-alive request sends the same closing sequence with no packet body, always with low-speed polarity.

The speed select is sampled once, when a packet is accepted, and sets which line is high for J. After the lines are released, the block holds off new requests for a guard time.

Top module: `bus_state_tx`

## Requirements
- R1: After reset the outputs are `oe`=0, `dp`=0 and `dm`=0. No strobe with no request pending changes them.
- R2: While the block is idle, a strobe with `pkt_valid`=1 raises `oe` and drives K as the first symbol, whatever `pkt_bit` is.
- R3: Each later strobe with `pkt_valid`=1 drives the stream bit: `pkt_bit`=1 gives J and `pkt_bit`=0 gives K.
- R4: At full speed (`low_speed`=0), J is `dp`=1,`dm`=0 and K is `dp`=0,`dm`=1. At low speed (`low_speed`=1) the two are swapped. The polarity is taken at acceptance, and later changes of `low_speed` within the packet have no effect.
- R5: A strobe in a packet with `pkt_valid`=0 starts the end sequence. SE0 (`dp`=`dm`=0, `oe`=1) is driven for two bit times, then J for one bit time, and `oe` falls on the strobe that ends that J.
- R6: While the block is idle, a strobe with `keepalive_req`=1 and `pkt_valid`=0 sends SE0, SE0, then a low-speed J (`dp`=0,`dm`=1), whatever `low_speed` is. When both requests are present, `pkt_valid` wins.
- R7: The block never drives `dp`=1 and `dm`=1 at the same time.
- R8: After `oe` falls, requests at the next `GAP_BITS` strobes are ignored and the lines stay released. A request at the strobe after those is accepted.
- R9: The outputs change only at clock edges where `bit_stb`=1.
- R10: Whenever `oe`=0, both `dp` and `dm` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_stb | input | 1 | One-cycle pulse at the start of each bit time |
| pkt_valid | input | 1 | Packet in progress; low at a strobe ends the packet |
| pkt_bit | input | 1 | Encoded stream bit, 1 = J, 0 = K |
| low_speed | input | 1 | Speed select, 1 = low-speed polarity |
| keepalive_req | input | 1 | Request a bodiless low-speed end sequence |
| dp | output | 1 | Drive value for the positive data line |
| dm | output | 1 | Drive value for the negative data line |
| oe | output | 1 | Output enable for both line drivers |

## Verification
Some properties depend only on the port values, and the checker tests these on every cycle. Both lines are never high together. Released lines read zero. Outputs hold between strobes. `oe` rises and falls only on strobes. A release always follows a differential J. An SE0 is always followed by a driven state.

Other behaviour depends on the symbol order and on polarity, and only the bench scenarios show it. This covers the forced K at the start, the J/K mapping at each speed, the polarity held after acceptance, the exact SE0-SE0-J order, keep-alive polarity and priority, and the guard strobes after release.

// File: rtl/bus_tx_pkg.sv
`timescale 1ns/1ps
package bus_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GAP,
        ST_DATA,
        ST_SE0_A,
        ST_SE0_B,
        ST_EOP_J
    } tx_state_e;

    typedef enum logic [1:0] {
        SYM_OFF,
        SYM_J,
        SYM_K,
        SYM_SE0
    } line_sym_e;

endpackage

// File: rtl/bus_tx_seq.sv
`timescale 1ns/1ps
module bus_tx_seq
    import bus_tx_pkg::*;
#(
    parameter int GAP_BITS = 1
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      bit_stb,
    input  logic      pkt_valid,
    input  logic      pkt_bit,
    input  logic      low_speed,
    input  logic      keepalive_req,
    output line_sym_e sym,
    output logic      ls_pol
);

    localparam int GW = $clog2(GAP_BITS + 1);
    localparam logic [GW-1:0] GAP_ONE  = GW'(1);
    localparam logic [GW-1:0] GAP_INIT = GW'(GAP_BITS);

    typedef struct packed {
        tx_state_e       state;
        line_sym_e       sym;
        logic            ls;
        logic [GW-1:0]   gap;
    } seq_t;

    seq_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (bit_stb) begin
            unique case (r_q.state)
                ST_IDLE: begin
                    if (pkt_valid) begin
                        r_d.state = ST_DATA;
                        r_d.sym   = SYM_K;
                        r_d.ls    = low_speed;
                    end else if (keepalive_req) begin
                        r_d.state = ST_SE0_A;
                        r_d.sym   = SYM_SE0;
                        r_d.ls    = 1'b1;
                    end
                end
                ST_DATA: begin
                    if (pkt_valid) begin
                        r_d.sym = pkt_bit ? SYM_J : SYM_K;
                    end else begin
                        r_d.state = ST_SE0_A;
                        r_d.sym   = SYM_SE0;
                    end
                end
                ST_SE0_A: begin
                    r_d.state = ST_SE0_B;
                    r_d.sym   = SYM_SE0;
                end
                ST_SE0_B: begin
                    r_d.state = ST_EOP_J;
                    r_d.sym   = SYM_J;
                end
                ST_EOP_J: begin
                    r_d.state = ST_GAP;
                    r_d.sym   = SYM_OFF;
                    r_d.gap   = GAP_INIT;
                end
                ST_GAP: begin
                    if (r_q.gap <= GAP_ONE) begin
                        r_d.state = ST_IDLE;
                        r_d.gap   = '0;
                    end else begin
                        r_d.gap = r_q.gap - GAP_ONE;
                    end
                end
                default: begin
                    r_d.state = ST_IDLE;
                    r_d.sym   = SYM_OFF;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.state <= ST_IDLE;
            r_q.sym   <= SYM_OFF;
            r_q.ls    <= 1'b0;
            r_q.gap   <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign sym    = r_q.sym;
    assign ls_pol = r_q.ls;

endmodule

// File: rtl/bus_tx_encode.sv
`timescale 1ns/1ps
module bus_tx_encode
    import bus_tx_pkg::*;
(
    input  line_sym_e sym,
    input  logic      ls_pol,
    output logic      dp,
    output logic      dm,
    output logic      oe
);

    always_comb begin
        dp = 1'b0;
        dm = 1'b0;
        oe = 1'b0;
        unique case (sym)
            SYM_J: begin
                dp = ~ls_pol;
                dm = ls_pol;
                oe = 1'b1;
            end
            SYM_K: begin
                dp = ls_pol;
                dm = ~ls_pol;
                oe = 1'b1;
            end
            SYM_SE0: begin
                oe = 1'b1;
            end
            default: begin
                oe = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/bus_state_tx.sv
`timescale 1ns/1ps
module bus_state_tx
    import bus_tx_pkg::*;
#(
    parameter int GAP_BITS = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_stb,
    input  logic pkt_valid,
    input  logic pkt_bit,
    input  logic low_speed,
    input  logic keepalive_req,
    output logic dp,
    output logic dm,
    output logic oe
);

    line_sym_e cur_sym;
    logic      cur_ls;

    bus_tx_seq #(
        .GAP_BITS (GAP_BITS)
    ) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .bit_stb       (bit_stb),
        .pkt_valid     (pkt_valid),
        .pkt_bit       (pkt_bit),
        .low_speed     (low_speed),
        .keepalive_req (keepalive_req),
        .sym           (cur_sym),
        .ls_pol        (cur_ls)
    );

    bus_tx_encode u_enc (
        .sym    (cur_sym),
        .ls_pol (cur_ls),
        .dp     (dp),
        .dm     (dm),
        .oe     (oe)
    );

endmodule

// File: rtl/bus_state_tx_chk.sv
`timescale 1ns/1ps
module bus_state_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic bit_stb,
    input logic dp,
    input logic dm,
    input logic oe
);

    a_r7_no_se1: assert property (@(posedge clk) disable iff (!rst_n)
        !(dp && dm));

    a_r10_released_low: assert property (@(posedge clk) disable iff (!rst_n)
        !oe |-> (!dp && !dm));

    a_r9_hold_between_strobes: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_stb |=> $stable({dp, dm, oe}));

    a_r2_oe_rise_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oe) |-> $past(bit_stb));

    a_r5_oe_fall_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(oe) |-> $past(bit_stb));

    a_r5_release_after_j: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(oe) |-> $past(dp != dm));

    a_r5_se0_then_driven: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_stb && oe && !dp && !dm) |=> oe);

endmodule

bind bus_state_tx bus_state_tx_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .bit_stb (bit_stb),
    .dp      (dp),
    .dm      (dm),
    .oe      (oe)
);

// File: tb/bus_state_tx_bench.sv
`timescale 1ns/1ps
module bus_state_tx_bench;

    localparam int GAP_BITS = 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_stb = 1'b0;
    logic pkt_valid = 1'b0;
    logic pkt_bit = 1'b0;
    logic low_speed = 1'b0;
    logic keepalive_req = 1'b0;
    logic dp, dm, oe;

    int n_checks = 0;
    int n_fails  = 0;
    int max_gap  = 0;
    logic [2:0] prev_out = 3'b000;

    always #2 clk = ~clk;

    bus_state_tx #(
        .GAP_BITS (GAP_BITS)
    ) u_bus_state_tx (
        .clk           (clk),
        .rst_n         (rst_n),
        .bit_stb       (bit_stb),
        .pkt_valid     (pkt_valid),
        .pkt_bit       (pkt_bit),
        .low_speed     (low_speed),
        .keepalive_req (keepalive_req),
        .dp            (dp),
        .dm            (dm),
        .oe            (oe)
    );

    // expected {dp,dm} for J (is_j=1) or K under a polarity
    function automatic logic [1:0] line_of(input logic is_j, input logic ls);
        logic j_dp;
        j_dp = ~ls;
        return is_j ? {j_dp, ~j_dp} : {~j_dp, j_dp};
    endfunction

    task automatic check(input string tag, input logic [2:0] exp_out);
        n_checks++;
        if ({dp, dm, oe} !== exp_out) begin
            n_fails++;
            $display("FAIL %s: actual dp/dm/oe=%b expected=%b at %0t", tag, {dp, dm, oe}, exp_out, $time);
        end
        n_checks++;
        if (dp && dm) begin
            n_fails++;
            $display("FAIL R7: actual dp/dm=11 expected not 11 at %0t", $time);
        end
    endtask

    // idle cycles without strobe (outputs must hold), then one strobe
    task automatic tick();
        int g;
        g = (max_gap > 0) ? $urandom_range(0, max_gap) : 0;
        for (int i = 0; i < g; i++) begin
            @(negedge clk);
            n_checks++;
            if ({dp, dm, oe} !== prev_out) begin
                n_fails++;
                $display("FAIL R9: actual dp/dm/oe=%b expected=%b", {dp, dm, oe}, prev_out);
            end
        end
        @(negedge clk);
        bit_stb = 1'b1;
        @(negedge clk);
        bit_stb = 1'b0;
        prev_out = {dp, dm, oe};
    endtask

    task automatic end_and_guard(input logic ls, input string tag);
        tick(); check(tag, 3'b001);                 // SE0 first bit
        tick(); check(tag, 3'b001);                 // SE0 second bit
        tick(); check(tag, {line_of(1'b1, ls), 1'b1}); // J
        tick(); check(tag, 3'b000);                 // released
        // R8: requests during the guard strobes are ignored
        pkt_valid = 1'b1;
        keepalive_req = 1'b1;
        for (int i = 0; i < GAP_BITS; i++) begin
            tick(); check("R8", 3'b000);
        end
        pkt_valid = 1'b0;
        keepalive_req = 1'b0;
    endtask

    task automatic send_packet(input int nbits, input logic ls, input logic ka_too);
        pkt_valid = 1'b1;
        low_speed = ls;
        keepalive_req = ka_too;
        pkt_bit = 1'b1;                             // first symbol is K regardless
        tick(); check(ka_too ? "R6" : "R2", {line_of(1'b0, ls), 1'b1});
        keepalive_req = 1'b0;
        for (int i = 0; i < nbits; i++) begin
            pkt_bit = 1'($urandom_range(0, 1));
            low_speed = 1'($urandom_range(0, 1));   // R4: must be ignored now
            tick(); check("R3 R4", {line_of(pkt_bit, ls), 1'b1});
        end
        pkt_valid = 1'b0;
        low_speed = 1'($urandom_range(0, 1));
        end_and_guard(ls, "R5");
    endtask

    task automatic send_keepalive();
        pkt_valid = 1'b0;
        keepalive_req = 1'b1;
        low_speed = 1'($urandom_range(0, 1));
        tick(); check("R6", 3'b001);
        keepalive_req = 1'b0;
        tick(); check("R6", 3'b001);
        tick(); check("R6", {line_of(1'b1, 1'b1), 1'b1});
        tick(); check("R6", 3'b000);
        pkt_valid = 1'b1;
        keepalive_req = 1'b1;
        for (int i = 0; i < GAP_BITS; i++) begin
            tick(); check("R8", 3'b000);
        end
        pkt_valid = 1'b0;
        keepalive_req = 1'b0;
    endtask

    initial begin
        #800000;
        n_fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check("R1", 3'b000);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", 3'b000);
        for (int i = 0; i < 3; i++) begin
            tick(); check("R1", 3'b000);
        end
        // directed corners
        send_packet(8, 1'b0, 1'b0);
        send_packet(8, 1'b1, 1'b0);
        send_packet(0, 1'b0, 1'b0);
        send_keepalive();
        send_packet(4, 1'b0, 1'b1);                 // R6 priority of packet
        // R8: request right at the guard end is accepted
        send_packet(2, 1'b1, 1'b0);
        // random mix with stretched bit times
        max_gap = 3;
        for (int n = 0; n < 40; n++) begin
            if ($urandom_range(0, 3) == 0) send_keepalive();
            else send_packet($urandom_range(0, 16), 1'($urandom_range(0, 1)),
                             1'($urandom_range(0, 1)));
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule